// File: doc/BRIEF.md
# Indirect Table Access Port

This block lets a register interface reach a set of internal configuration tables through two registers: a pointer register that selects a table and an entry, and a 64-bit data register through which that entry is read or written. The tables have different depths. Each access masks the pointer's index to the depth of the selected table. When the pointer's step flag is set, every data access moves the index on by one, wrapping inside that table.

Seven table codes are recognised. Five are backed by storage. Two are accepted but hold nothing: they read as zero and ignore writes. Codes above the recognised range are rejected with an error pulse and touch nothing. Writes to the interrupt-vector table and the window table also emit a one-cycle side-effect strobe for the logic that owns those tables.

Top module: `tbl_access_port`

## Requirements
- R1: A write with `reg_sel_i`=0 loads the pointer register. Index is bits [IDX_W-1:0], table code is bits [19:16] and the step flag is bit 31. A read with `reg_sel_i`=0 returns those fields in the same positions, with every other bit zero.
- R2: A data write (`reg_sel_i`=1) to a backed table (codes 0 list, 3 translation, 4 window, 6 event) stores the full 64-bit value. A later data read of the same entry returns it. Read data appears on `rdata_o`, with `rvalid_o` high, in the cycle after the request.
- R3: A data access uses the pointer index ANDed with the selected table's depth minus one, so index values beyond the depth alias onto lower entries.
- R4: With the step flag set, each accepted data access (read or write) sets the index to (masked index + 1) masked, so it wraps at the table depth. The new index is visible in the pointer register. With the flag clear, the index does not change.
- R5: Codes 2 and 5 are recognised but unbacked. Data reads return zero and data writes change nothing, and the index still steps when the flag is set.
- R6: A data access with a table code of 7 to 15 pulses `err_o` in the next cycle. A read returns zero. No table entry changes, no strobe fires and the index does not step.
- R7: A write to the interrupt-vector table (code 1) keeps only server bits [39:24], node bits [19:16] and priority bits [7:0]. All other bits read back as zero.
- R8: A write to code 1 raises `fx_valid_o` for one cycle in the next cycle. The strobe carries table 1, the masked index from before the step, the server field shifted right by two (value bits [39:26]) and the priority (bits [7:0]).
- R9: A write to the window table (code 4) raises the strobe with table 4 and the masked pre-step index, with server and priority zero. No other access raises the strobe.
- R10: After reset, the pointer register reads zero, all table entries read zero, and `rvalid_o`, `err_o` and `fx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 1 | 0 = pointer register, 1 = data register |
| wdata_i | input | 64 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 64 | Read data |
| err_o | output | 1 | Illegal table code on a data access |
| fx_valid_o | output | 1 | Side-effect strobe |
| fx_table_o | output | 4 | Table code of the strobe |
| fx_index_o | output | IDX_W | Entry index of the strobe, before the step |
| fx_server_o | output | 14 | Server number with the link-pointer bits dropped |
| fx_prio_o | output | 8 | Priority of the vector write |

## Verification
The hardest case to reach is a step that wraps while the pointer index sits above the table depth. Only the masked value may advance, so a stale high index must collapse to the bottom of the table and not carry upward. The stimulus loads indices up to 63 into shallow tables with the step flag set. It then issues runs of data accesses and reads the pointer back, mixing in illegal codes so that a frozen index can be told apart from a wrapped one. A behavioural model is compared against every output on every cycle of a long random stream that follows the directed cases.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int NUM_TBL = 7;
  localparam int SEL_W   = 4;
  localparam int SEL_LSB = 16;
  localparam int INC_BIT = 31;
  localparam int SRV_LSB = 24;
  localparam int SRV_W   = 14;
  localparam int PRIO_W  = 8;
  localparam logic [63:0] VEC_KEEP = 64'h0000_00FF_FF0F_00FF;
  localparam logic [63:0] ALL_KEEP = '1;

  typedef enum logic [SEL_W-1:0] {
    TBL_LIST = 4'd0,
    TBL_VEC  = 4'd1,
    TBL_CAM  = 4'd2,
    TBL_XLT  = 4'd3,
    TBL_WIN  = 4'd4,
    TBL_PEND = 4'd5,
    TBL_EVT  = 4'd6
  } tbl_e;

  function automatic logic tbl_backed(input int t);
    return (t == int'(TBL_LIST)) || (t == int'(TBL_VEC)) || (t == int'(TBL_XLT)) ||
           (t == int'(TBL_WIN)) || (t == int'(TBL_EVT));
  endfunction
endpackage

// File: rtl/tap_addr_reg.sv
module tap_addr_reg
  import tap_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic             ld_inc_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             inc_o,
  output logic [63:0]      word_o
);
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      idx_q <= '0;
      inc_q <= 1'b0;
    end else if (ld_i) begin
      sel_q <= ld_sel_i;
      idx_q <= ld_idx_i;
      inc_q <= ld_inc_i;
    end else if (adv_i) begin
      idx_q <= ((idx_q & mask_i) + IDX_W'(1)) & mask_i;
    end
  end

  always_comb begin
    word_o = '0;
    word_o[IDX_W-1:0]         = idx_q;
    word_o[SEL_LSB +: SEL_W]  = sel_q;
    word_o[INC_BIT]           = inc_q;
  end

  assign sel_o = sel_q;
  assign idx_o = idx_q;
  assign inc_o = inc_q;
endmodule

// File: rtl/tap_table_bank.sv
module tap_table_bank #(
  parameter int          DEPTH = 8,
  parameter logic [63:0] KEEP  = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [63:0]              wdata_i,
  output logic [63:0]              rdata_o
);
  logic [63:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i & KEEP;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/tap_fx.sv
module tap_fx
  import tap_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [SEL_W-1:0]  tbl_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SRV_W-1:0]  srv_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              valid_o,
  output logic [SEL_W-1:0]  tbl_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic is_vec;
  assign is_vec = (tbl_i == TBL_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tbl_o   <= '0;
      idx_o   <= '0;
      srv_o   <= '0;
      prio_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        tbl_o  <= tbl_i;
        idx_o  <= idx_i;
        srv_o  <= is_vec ? srv_i : '0;
        prio_o <= is_vec ? prio_i : '0;
      end
    end
  end
endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port
  import tap_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int LIST_DEPTH = 8,
  parameter int VEC_DEPTH  = 8,
  parameter int CAM_DEPTH  = 16,
  parameter int XLT_DEPTH  = 16,
  parameter int WIN_DEPTH  = 8,
  parameter int PEND_DEPTH = 4,
  parameter int EVT_DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              reg_sel_i,
  input  logic [63:0]       wdata_i,
  output logic              rvalid_o,
  output logic [63:0]       rdata_o,
  output logic              err_o,
  output logic              fx_valid_o,
  output logic [SEL_W-1:0]  fx_table_o,
  output logic [IDX_W-1:0]  fx_index_o,
  output logic [SRV_W-1:0]  fx_server_o,
  output logic [PRIO_W-1:0] fx_prio_o
);
  localparam int DEP [NUM_TBL] = '{LIST_DEPTH, VEC_DEPTH, CAM_DEPTH, XLT_DEPTH,
                                   WIN_DEPTH, PEND_DEPTH, EVT_DEPTH};

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx, mask, idx_eff;
  logic             inc;
  logic [63:0]      ptr_word;
  logic             sel_ok, acc, acc_ok, wr_tbl, fire;
  logic [63:0]      rd_arr [NUM_TBL];
  logic [63:0]      rd_tbl, rd_next;

  assign acc     = req_i && reg_sel_i;
  assign sel_ok  = (int'(sel) < NUM_TBL);
  assign acc_ok  = acc && sel_ok;
  assign wr_tbl  = acc_ok && we_i;
  assign idx_eff = idx & mask;
  assign fire    = wr_tbl && ((sel == TBL_VEC) || (sel == TBL_WIN));

  always_comb begin
    mask   = '0;
    rd_tbl = '0;
    for (int t = 0; t < NUM_TBL; t++) begin
      if (int'(sel) == t) begin
        mask   = IDX_W'(DEP[t] - 1);
        rd_tbl = rd_arr[t];
      end
    end
  end

  tap_addr_reg #(.IDX_W(IDX_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (req_i && we_i && !reg_sel_i),
    .ld_sel_i (wdata_i[SEL_LSB +: SEL_W]),
    .ld_idx_i (wdata_i[IDX_W-1:0]),
    .ld_inc_i (wdata_i[INC_BIT]),
    .adv_i    (acc_ok && inc),
    .mask_i   (mask),
    .sel_o    (sel),
    .idx_o    (idx),
    .inc_o    (inc),
    .word_o   (ptr_word)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    if (tbl_backed(t)) begin : g_store
      localparam int AW = $clog2(DEP[t]);
      tap_table_bank #(
        .DEPTH (DEP[t]),
        .KEEP  ((t == int'(TBL_VEC)) ? VEC_KEEP : ALL_KEEP)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_tbl && (int'(sel) == t)),
        .idx_i   (idx_eff[AW-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (rd_arr[t])
      );
    end else begin : g_empty
      assign rd_arr[t] = '0;
    end
  end

  always_comb begin
    if (!reg_sel_i)  rd_next = ptr_word;
    else if (sel_ok) rd_next = rd_tbl;
    else             rd_next = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      rdata_o  <= (req_i && !we_i) ? rd_next : '0;
      err_o    <= acc && !sel_ok;
    end
  end

  // server low two bits are a link pointer and are dropped
  tap_fx #(.IDX_W(IDX_W)) u_fx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .tbl_i   (sel),
    .idx_i   (idx_eff),
    .srv_i   (wdata_i[SRV_LSB+2 +: SRV_W]),
    .prio_i  (wdata_i[PRIO_W-1:0]),
    .valid_o (fx_valid_o),
    .tbl_o   (fx_table_o),
    .idx_o   (fx_index_o),
    .srv_o   (fx_server_o),
    .prio_o  (fx_prio_o)
  );
endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              reg_sel_i,
  input logic              rvalid_o,
  input logic [63:0]       rdata_o,
  input logic              err_o,
  input logic              fx_valid_o,
  input logic [SEL_W-1:0]  fx_table_o,
  input logic [SRV_W-1:0]  fx_server_o,
  input logic [PRIO_W-1:0] fx_prio_o
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R2
  AST_ERR_FROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && reg_sel_i)); // R6
  AST_ERR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && rvalid_o) |-> (rdata_o == 64'd0)); // R6
  AST_ERR_NO_FX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !fx_valid_o); // R6
  AST_FX_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_valid_o |-> $past(req_i && we_i && reg_sel_i)); // R8
  AST_FX_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_valid_o |-> (fx_table_o == 4'd1 || fx_table_o == 4'd4)); // R9
  AST_WIN_NO_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fx_valid_o && fx_table_o == 4'd4) |-> (fx_server_o == '0 && fx_prio_o == '0)); // R9
endmodule

bind tbl_access_port tap_port_chk u_chk (.*);

// File: tb/tb_tbl_access_port.sv
`timescale 1ns/1ps
module tb_tbl_access_port;
  localparam int IDX_W = 6;
  localparam logic [63:0] KEEP_V = 64'h0000_00FF_FF0F_00FF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, reg_sel_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic rvalid_o, err_o, fx_valid_o;
  logic [63:0] rdata_o;
  logic [3:0] fx_table_o;
  logic [IDX_W-1:0] fx_index_o;
  logic [13:0] fx_server_o;
  logic [7:0] fx_prio_o;

  always #5 clk_i = ~clk_i;

  tbl_access_port dut (.*);

  int checks = 0, fails = 0;
  int depth [7] = '{8, 8, 16, 16, 8, 4, 4};
  logic [63:0] mdl [7][64];
  int m_sel = 0, m_idx = 0;
  bit m_inc = 0;

  logic e_rv, e_err, e_fx;
  logic [63:0] e_rd;
  int e_ft, e_fi, e_fs, e_fp;

  function automatic bit backed(int t);
    return t == 0 || t == 1 || t == 3 || t == 4 || t == 6;
  endfunction

  task automatic model(bit rq, bit we, bit rs, logic [63:0] d);
    int e;
    e_rv = rq && !we; e_err = 0; e_rd = '0; e_fx = 0;
    e_ft = 0; e_fi = 0; e_fs = 0; e_fp = 0;
    if (rq && !rs) begin
      if (we) begin
        m_sel = int'(d[19:16]); m_idx = int'(d[5:0]); m_inc = d[31];
      end else begin
        e_rd = (64'(m_inc) << 31) | (64'(m_sel) << 16) | 64'(m_idx);
      end
    end else if (rq && rs) begin
      if (m_sel > 6) e_err = 1;
      else begin
        e = m_idx % depth[m_sel];
        if (we) begin
          if (backed(m_sel)) mdl[m_sel][e] = (m_sel == 1) ? (d & KEEP_V) : d;
          if (m_sel == 1) begin
            e_fx = 1; e_ft = 1; e_fi = e; e_fs = int'(d[39:26]); e_fp = int'(d[7:0]);
          end else if (m_sel == 4) begin
            e_fx = 1; e_ft = 4; e_fi = e;
          end
        end else begin
          e_rd = backed(m_sel) ? mdl[m_sel][e] : 64'd0;
        end
        if (m_inc) m_idx = (e + 1) % depth[m_sel];
      end
    end
  endtask

  task automatic op(bit rq, bit we, bit rs, logic [63:0] d, string tag);
    req_i = rq; we_i = we; reg_sel_i = rs; wdata_i = d;
    @(posedge clk_i);
    model(rq, we, rs, d);
    @(negedge clk_i);
    req_i = 0; we_i = 0; reg_sel_i = 0;
    checks++;
    if (rvalid_o !== e_rv || rdata_o !== e_rd || err_o !== e_err || fx_valid_o !== e_fx ||
        (e_fx && (int'(fx_table_o) != e_ft || int'(fx_index_o) != e_fi ||
                  int'(fx_server_o) != e_fs || int'(fx_prio_o) != e_fp))) begin
      fails++;
      $display("FAIL %s: act rv=%0b rd=%h err=%0b fx=%0b t=%0d i=%0d s=%0d p=%0d exp rv=%0b rd=%h err=%0b fx=%0b t=%0d i=%0d s=%0d p=%0d",
               tag, rvalid_o, rdata_o, err_o, fx_valid_o, fx_table_o, fx_index_o, fx_server_o,
               fx_prio_o, e_rv, e_rd, e_err, e_fx, e_ft, e_fi, e_fs, e_fp);
    end
  endtask

  function automatic logic [63:0] ptr(int s, int i, bit inc);
    return (64'(inc) << 31) | (64'(s) << 16) | 64'(i);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 7; t++) for (int i = 0; i < 64; i++) mdl[t][i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    op(0, 0, 0, '0, "R10 idle");
    op(1, 0, 0, '0, "R10 pointer");
    op(1, 0, 1, '0, "R10 table zero");
    // R1 pointer fields, junk elsewhere
    op(1, 1, 0, 64'hF0F0_0000_7FF3_FFC5 & ~64'h8000_0000, "R1 load");
    op(1, 0, 0, '0, "R1 readback");
    op(1, 1, 0, 64'hFFFF_FFFF_8003_0005, "R1 load inc");
    op(1, 0, 0, '0, "R1 readback inc");
    // R2 store and read back on translation table
    op(1, 1, 0, ptr(3, 5, 0), "R2 ptr");
    op(1, 1, 1, 64'hDEAD_BEEF_0123_4567, "R2 write");
    op(1, 0, 1, '0, "R2 read");
    op(1, 0, 0, '0, "R4 no step");
    // R4 step and wrap on list table
    op(1, 1, 0, ptr(0, 6, 1), "R4 ptr");
    op(1, 1, 1, 64'h11, "R4 w6");
    op(1, 1, 1, 64'h22, "R4 w7");
    op(1, 1, 1, 64'h33, "R4 w0 wrap");
    op(1, 0, 0, '0, "R4 index after wrap");
    op(1, 1, 0, ptr(0, 63, 1), "R4 high ptr");
    op(1, 0, 1, '0, "R4 read aliased 7");
    op(1, 0, 0, '0, "R4 collapsed index");
    // R3 alias
    op(1, 1, 0, ptr(0, 14, 0), "R3 ptr");
    op(1, 0, 1, '0, "R3 alias read");
    // R7 R8 vector table
    op(1, 1, 0, ptr(1, 10, 1), "R8 ptr");
    op(1, 1, 1, '1, "R8 vec strobe");
    op(1, 1, 0, ptr(1, 2, 0), "R7 ptr");
    op(1, 0, 1, '0, "R7 masked readback");
    op(1, 1, 1, 64'h1234_5678_9ABC_DEF0, "R8 vec strobe 2");
    op(1, 0, 1, '0, "R7 masked readback 2");
    // R9 window
    op(1, 1, 0, ptr(4, 7, 1), "R9 ptr");
    op(1, 1, 1, 64'hAAAA, "R9 win strobe");
    op(1, 1, 1, 64'hBBBB, "R9 win wrap strobe");
    op(1, 0, 1, '0, "R9 read no strobe");
    // R5 unbacked
    op(1, 1, 0, ptr(2, 3, 1), "R5 ptr");
    op(1, 1, 1, '1, "R5 write ignored");
    op(1, 1, 0, ptr(2, 3, 1), "R5 ptr again");
    op(1, 0, 1, '0, "R5 read zero");
    op(1, 0, 0, '0, "R5 still steps");
    // R6 illegal
    op(1, 1, 0, ptr(9, 1, 1), "R6 ptr");
    op(1, 1, 1, '1, "R6 write err");
    op(1, 0, 1, '0, "R6 read err");
    op(1, 0, 0, '0, "R6 no step");
    op(1, 1, 0, ptr(0, 1, 0), "R6 ptr list");
    op(1, 0, 1, '0, "R6 list intact");
    // random stream
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom % 10;
      logic [63:0] d = {$urandom, $urandom};
      if (k < 2) op(1, 1, 0, ptr($urandom % 10, $urandom % 64, 1'($urandom % 2)), "R4 rnd ptr");
      else if (k < 3) op(1, 0, 0, '0, "R1 rnd ptr read");
      else if (k < 6) op(1, 1, 1, d, "R2 rnd write");
      else if (k < 9) op(1, 0, 1, '0, "R2 rnd read");
      else op(0, 0, 0, '0, "R9 rnd idle");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule